// File: doc/BRIEF.md
# SMBus Register Target with Byte and Block Transfers

This block is a two-wire serial bus target (SMBus/I2C compatible) that holds a small file of eight-bit control registers for the rest of the chip. It watches the bus clock and data lines, which are sampled by the system clock through a synchronizer. It answers only its fixed device address and acknowledges or returns data by pulling the data line low through an open-drain output enable. Register contents are exposed as a flat vector. Six per-output enable bits are decoded from two of the registers. These enable bits come out of reset with every output enabled.

A bus master reaches the file with single-byte writes and reads, or with block transfers. The command byte that follows the address chooses the starting register and the transfer style. Block writes carry a byte count ahead of their data. Block reads return the count register before the data. Consecutive bytes move through the file from lower to higher index. A master may end any transfer with a stop after any whole byte.

Top module: `smbreg_slave`

## Requirements
- R1: After reset the registers read, from index 0 upward, 0x00, 0x15, 0xE0, 0x08, 0x06 and 0xD8 (`regsOut` byte i holds register i). `outEn` is all ones and `sdaOe` is low.
- R2: The target acknowledges an address byte whose upper seven bits equal 0x6B (0xD6 to write, 0xD7 to read). Any other address gets no acknowledge. The rest of that transaction is ignored until the next start, and no register changes.
- R3: A byte write is a command byte with bit 7 clear, whose bits 6:0 give the register index, followed by one data byte. Address, command and data are each acknowledged, and the data byte lands in that register.
- R4: A byte read is a command byte with bit 7 clear, a repeated start and the read address. The target then drives the indexed register MSB first and releases the data line for the master's acknowledge bit.
- R5: A block write is a command byte with bit 7 set, whose bits 6:0 give the starting index, then a count byte, then data. The target acknowledges the count and exactly that many data bytes and writes them to consecutive registers. Later data bytes get no acknowledge and are discarded. The count byte itself is not stored.
- R6: A block read is a command byte with bit 7 set, a repeated start and the read address. The target returns register 4 first, then consecutive registers from the starting index, for as long as the master acknowledges.
- R7: An index at or above 6 is acknowledged. A write to it changes no register, and a read of it returns 0x00.
- R8: `outEn[0..2]` follow register 1 bits 4, 2 and 0. `outEn[3..5]` follow register 2 bits 7, 6 and 5.
- R9: A stop after any whole byte ends the transfer. Bytes already written in a cut-short block write are kept.
- R10: `sdaOe` changes only in response to a falling bus clock edge, a start or a stop. It never changes while the bus clock is high in mid-bit.
- R11: A stop releases the data line and returns the target to idle. A stop after only the command byte writes nothing, and the next transaction is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | When high, the data line is pulled low |
| outEn | output | 6 | Per-output enable bits decoded from registers 1 and 2 |
| regsOut | output | 48 | Register file contents, byte i is register i |

## Verification
A wrong pointer or count inside the target shows up on the bus within one byte time. It appears as a misplaced acknowledge on block writes, or as read data drawn from the wrong register. A wrong bit counter or state shows as a data or acknowledge bit driven one bus clock early or late, so the next sampled bit at the master is wrong. A bad write path shows up on `regsOut` and `outEn` as soon as the acknowledge of the data byte has begun.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACKW, ST_ACK, ST_TX, ST_MACK, ST_SKIP
  } ctrl_state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_COUNT, PH_DATA
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rxShift;
    logic txShift;
    logic txLoadCount;
    logic txLoadPtr;
    logic ptrSet;
    logic regWrite;
    logic remainSet;
    logic remainDec;
    logic ackDrive;
    logic txDrive;
  } strobe_t;

  // enable n lives in register 1 (n<3) or register 2 (n>=3)
  function automatic int oeRegIdx(input int n);
    return (n < 3) ? 1 : 2;
  endfunction

  function automatic int oeBitPos(input int n);
    return (n < 3) ? (4 - 2 * n) : (7 - (n - 3));
  endfunction

endpackage

// File: rtl/smbreg_line.sv
module smbreg_line #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;
  logic sclLvl;

  assign sclLvl = sclPipe[SYNC_STAGES-1];
  assign sdaLvl = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclRise = sclLvl & ~sclPrev;
  assign sclFall = ~sclLvl & sclPrev;
  assign startEv = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopEv  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/smbreg_ctrl.sv
module smbreg_ctrl
  import smbreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6B
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       sdaLvl,
  input  logic [7:0] rxByte,
  input  logic       remainZero,
  output strobe_t    st
);
  localparam logic [2:0] LAST_BIT = 3'd7;

  ctrl_state_e state;
  phase_e      phase;
  logic [2:0]  bitCnt;
  logic        isRead;
  logic        blockMode;
  logic        ackOn;
  logic        mAck;
  logic        dataAccept;

  assign dataAccept = !(blockMode && remainZero);

  always_comb begin
    st = '0;
    st.rxShift  = (state == ST_RX) && sclRise;
    st.txShift  = (state == ST_TX) && sclFall && (bitCnt != LAST_BIT);
    st.ackDrive = (state == ST_ACK) && ackOn;
    st.txDrive  = (state == ST_TX);
    if ((state == ST_ACKW) && sclFall) begin
      case (phase)
        PH_CMD:   st.ptrSet = 1'b1;
        PH_COUNT: st.remainSet = 1'b1;
        PH_DATA: begin
          st.regWrite  = dataAccept;
          st.remainDec = dataAccept && blockMode;
        end
        default: ;
      endcase
    end
    if ((state == ST_ACK) && sclFall && isRead) begin
      st.txLoadCount = blockMode;
      st.txLoadPtr   = !blockMode;
    end
    if ((state == ST_MACK) && sclFall && mAck) st.txLoadPtr = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= PH_ADDR;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      blockMode <= 1'b0;
      ackOn     <= 1'b0;
      mAck      <= 1'b0;
    end else if (startEv) begin
      state  <= ST_RX;
      phase  <= PH_ADDR;
      bitCnt <= '0;
    end else if (stopEv) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_RX: if (sclRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == LAST_BIT) state <= ST_ACKW;
        end
        ST_ACKW: if (sclFall) begin
          state <= ST_ACK;
          ackOn <= 1'b1;
          case (phase)
            PH_ADDR: begin
              if (rxByte[7:1] == DEV_ADDR) isRead <= rxByte[0];
              else state <= ST_SKIP;
            end
            PH_CMD:  blockMode <= rxByte[7];
            PH_DATA: ackOn <= dataAccept;
            default: ;
          endcase
        end
        ST_ACK: if (sclFall) begin
          bitCnt <= '0;
          if (isRead) begin
            state <= ST_TX;
          end else begin
            state <= ST_RX;
            case (phase)
              PH_ADDR:  phase <= PH_CMD;
              PH_CMD:   phase <= blockMode ? PH_COUNT : PH_DATA;
              default:  phase <= PH_DATA;
            endcase
          end
        end
        ST_TX: if (sclFall) begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == LAST_BIT) state <= ST_MACK;
        end
        ST_MACK: begin
          if (sclRise) mAck <= ~sdaLvl;
          if (sclFall) state <= mAck ? ST_TX : ST_SKIP;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/smbreg_datapath.sv
module smbreg_datapath
  import smbreg_pkg::*;
#(
  parameter int                      NUM_REGS   = 6,
  parameter int                      COUNT_IDX  = 4,
  parameter int                      PTR_W      = 7,
  parameter logic [NUM_REGS*8-1:0]   RESET_VALS = 48'hD8_06_08_E0_15_00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               st,
  input  logic                  sdaLvl,
  output logic [7:0]            rxByte,
  output logic                  remainZero,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regsOut
);
  localparam int               IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PTR_W-1:0] REG_LIMIT = PTR_W'(NUM_REGS);

  logic [7:0]       regFile [NUM_REGS];
  logic [7:0]       rxShiftReg;
  logic [7:0]       txShiftReg;
  logic [7:0]       remain;
  logic [PTR_W-1:0] ptr;
  logic             inRange;
  logic [7:0]       rdData;

  assign inRange    = ptr < REG_LIMIT;
  assign rdData     = inRange ? regFile[ptr[IDX_W-1:0]] : 8'h00;
  assign rxByte     = rxShiftReg;
  assign remainZero = (remain == 8'h00);
  assign sdaOe      = st.ackDrive | (st.txDrive & ~txShiftReg[7]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= RESET_VALS[i*8 +: 8];
      rxShiftReg <= '0;
      txShiftReg <= '1;
      remain     <= '0;
      ptr        <= '0;
    end else begin
      if (st.rxShift)   rxShiftReg <= {rxShiftReg[6:0], sdaLvl};
      if (st.ptrSet)    ptr <= rxShiftReg[PTR_W-1:0];
      if (st.remainSet) remain <= rxShiftReg;
      if (st.remainDec) remain <= remain - 8'd1;
      if (st.regWrite) begin
        if (inRange) regFile[ptr[IDX_W-1:0]] <= rxShiftReg;
        ptr <= ptr + 1'b1;
      end
      if (st.txLoadCount) txShiftReg <= regFile[COUNT_IDX];
      if (st.txLoadPtr) begin
        txShiftReg <= rdData;
        ptr        <= ptr + 1'b1;
      end
      if (st.txShift) txShiftReg <= {txShiftReg[6:0], 1'b0};
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_regOut
    assign regsOut[g*8 +: 8] = regFile[g];
  end

endmodule

// File: rtl/smbreg_slave.sv
module smbreg_slave
  import smbreg_pkg::*;
#(
  parameter logic [6:0]            DEV_ADDR    = 7'h6B,
  parameter int                    NUM_REGS    = 6,
  parameter int                    COUNT_IDX   = 4,
  parameter int                    NUM_OUT     = 6,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [NUM_REGS*8-1:0] RESET_VALS  = 48'hD8_06_08_E0_15_00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_OUT-1:0]    outEn,
  output logic [NUM_REGS*8-1:0] regsOut
);
  logic       sdaLvl, sclRise, sclFall, startEv, stopEv;
  logic [7:0] rxByte;
  logic       remainZero;
  strobe_t    st;

  smbreg_line #(.SYNC_STAGES(SYNC_STAGES)) uLine (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  smbreg_ctrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .remainZero(remainZero), .st(st)
  );

  smbreg_datapath #(
    .NUM_REGS(NUM_REGS), .COUNT_IDX(COUNT_IDX), .RESET_VALS(RESET_VALS)
  ) uData (
    .clk(clk), .rstN(rstN), .st(st), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .remainZero(remainZero), .sdaOe(sdaOe),
    .regsOut(regsOut)
  );

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_outEn
    assign outEn[n] = regsOut[oeRegIdx(n) * 8 + oeBitPos(n)];
  end

endmodule

// File: rtl/smbreg_checker.sv
module smbreg_checker
  import smbreg_pkg::*;
#(
  parameter int REG_BITS = 48
) (
  input logic                clk,
  input logic                rstN,
  input logic                sclFall,
  input logic                startEv,
  input logic                stopEv,
  input logic                remainZero,
  input strobe_t             st,
  input logic                sdaOe,
  input logic [REG_BITS-1:0] regsOut
);

  // R10: the data drive only moves after a clock fall, start or stop
  assert_drive_timing_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> $past(sclFall || startEv || stopEv));

  // R11: a stop leaves the line released
  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaOe);

  // R5: the block count is never consumed past zero
  assert_count_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.remainDec |-> !remainZero);

  // R3: registers move only on an accepted data byte
  assert_write_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regsOut) |-> $past(st.regWrite));

endmodule

bind smbreg_slave smbreg_checker #(.REG_BITS(NUM_REGS * 8)) uChk (
  .clk(clk), .rstN(rstN), .sclFall(sclFall), .startEv(startEv),
  .stopEv(stopEv), .remainZero(remainZero), .st(st), .sdaOe(sdaOe),
  .regsOut(regsOut)
);

// File: tb/tb_smbreg_slave.sv
module tb_smbreg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 8;
  localparam int WATCHDOG   = 180000;
  localparam logic [47:0] RST_VALS = 48'hD8_06_08_E0_15_00;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaOe;
  logic [5:0]  outEn;
  logic [47:0] regsOut;
  logic        sdaLine;

  assign sdaLine = sdaM & ~sdaOe;

  smbreg_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .outEn(outEn), .regsOut(regsOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int   nChecks = 0;
  int   nFails = 0;
  int   r10Viol = 0;
  bit   done = 1'b0;
  logic prevOe = 1'b0;
  logic [7:0] model [6];

  always @(negedge clk) begin
    if (rstN && sclM && (sdaOe !== prevOe)) r10Viol++;
    prevOe = sdaOe;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] modelFlat();
    logic [47:0] f;
    for (int i = 0; i < 6; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  function automatic logic [5:0] expOe();
    return {model[2][5], model[2][6], model[2][7], model[1][0], model[1][2], model[1][4]};
  endfunction

  function automatic logic [7:0] modelRd(input int idx);
    return (idx < 6) ? model[idx] : 8'h00;
  endfunction

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic sendStart();
    sdaM = 1'b1; qwait(); sclM = 1'b1; qwait(); sdaM = 1'b0; qwait(); sclM = 1'b0; qwait();
  endtask

  task automatic sendStop();
    sdaM = 1'b0; qwait(); sclM = 1'b1; qwait(); sdaM = 1'b1; qwait(); qwait();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      qwait(); sdaM = b[i]; qwait(); sclM = 1'b1; qwait(); qwait(); sclM = 1'b0;
    end
    qwait(); sdaM = 1'b1; qwait(); sclM = 1'b1; qwait(); ack = ~sdaLine; qwait(); sclM = 1'b0;
  endtask

  task automatic readByte(input logic masterAck, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      qwait(); sdaM = 1'b1; qwait(); sclM = 1'b1; qwait(); d[i] = sdaLine; qwait(); sclM = 1'b0;
    end
    qwait(); sdaM = ~masterAck; qwait(); sclM = 1'b1; qwait(); qwait(); sclM = 1'b0;
  endtask

  task automatic doByteWrite(input logic [6:0] idx, input logic [7:0] d, output logic [2:0] acks);
    sendStart();
    writeByte(8'hD6, acks[0]);
    writeByte({1'b0, idx}, acks[1]);
    writeByte(d, acks[2]);
    sendStop();
  endtask

  task automatic doByteRead(input logic [6:0] idx, output logic [7:0] d, output logic [2:0] acks);
    sendStart();
    writeByte(8'hD6, acks[0]);
    writeByte({1'b0, idx}, acks[1]);
    sendStart();
    writeByte(8'hD7, acks[2]);
    readByte(1'b0, d);
    sendStop();
  endtask

  // sends nSend data bytes base, base+0x11, ...; ackMask bit j is the ack of data byte j
  task automatic doBlockWrite(input logic [6:0] idx, input logic [7:0] cnt, input int nSend,
                              input logic [7:0] base, output logic [2:0] hdr, output logic [7:0] ackMask);
    logic a;
    ackMask = '0;
    sendStart();
    writeByte(8'hD6, hdr[0]);
    writeByte({1'b1, idx}, hdr[1]);
    writeByte(cnt, hdr[2]);
    for (int j = 0; j < nSend; j++) begin
      writeByte(base + 8'(j * 17), a);
      ackMask[j] = a;
    end
    sendStop();
  endtask

  task automatic blockWriteModel(input int idx, input int cnt, input int nSend, input logic [7:0] base);
    for (int j = 0; j < nSend; j++)
      if (j < cnt && idx + j < 6) model[idx + j] = base + 8'(j * 17);
  endtask

  task automatic doBlockRead(input logic [6:0] idx, input int n, output logic [7:0] cntByte,
                             output logic [31:0] data, output logic [2:0] hdr);
    logic [7:0] d;
    data = '0;
    sendStart();
    writeByte(8'hD6, hdr[0]);
    writeByte({1'b1, idx}, hdr[1]);
    sendStart();
    writeByte(8'hD7, hdr[2]);
    readByte(1'b1, cntByte);
    for (int j = 0; j < n; j++) begin
      readByte(j < n - 1, d);
      data[j*8 +: 8] = d;
    end
    sendStop();
  endtask

  function automatic logic [31:0] expBlock(input int idx, input int n);
    logic [31:0] e = '0;
    for (int j = 0; j < n; j++) e[j*8 +: 8] = modelRd(idx + j);
    return e;
  endfunction

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=complete");
      finishRun();
    end
  end

  initial begin
    logic [2:0]  acks;
    logic [7:0]  d;
    logic [7:0]  mask;
    logic [7:0]  cntByte;
    logic [31:0] blk;
    logic        a;
    void'($urandom(32'd2024));
    for (int i = 0; i < 6; i++) model[i] = RST_VALS[i*8 +: 8];

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 regs", regsOut, RST_VALS);
    check("R1 outEn", outEn, 6'h3f);
    check("R1 sdaOe", sdaOe, 1'b0);

    // R4 byte read of a reset value
    doByteRead(7'd5, d, acks);
    check("R4 acks", acks, 3'b111);
    check("R4 data", d, 8'hD8);

    // R8 enable mapping
    doByteWrite(7'd1, 8'h10, acks);
    model[1] = 8'h10;
    check("R3 acks", acks, 3'b111);
    check("R8 outEn reg1", outEn, 6'h39);
    doByteWrite(7'd2, 8'h40, acks);
    model[2] = 8'h40;
    check("R8 outEn reg2", outEn, 6'h11);

    // R2 foreign address
    sendStart();
    writeByte(8'hA0, a);
    check("R2 addr nack", a, 1'b0);
    writeByte(8'h01, a);
    check("R2 later byte ignored", a, 1'b0);
    sendStop();
    check("R2 regs unchanged", regsOut, modelFlat());

    // R7 out of range index
    doByteWrite(7'd9, 8'hAA, acks);
    check("R7 write acks", acks, 3'b111);
    check("R7 regs unchanged", regsOut, modelFlat());
    doByteRead(7'd9, d, acks);
    check("R7 read zero", d, 8'h00);

    // R5 block write with one byte beyond the count
    doBlockWrite(7'd1, 8'd2, 3, 8'h11, acks, mask);
    blockWriteModel(1, 2, 3, 8'h11);
    check("R5 header acks", acks, 3'b111);
    check("R5 data acks", mask, 8'b011);
    check("R5 regs", regsOut, modelFlat());

    // R6 block read returns count register first
    doBlockRead(7'd0, 3, cntByte, blk, acks);
    check("R6 count byte", cntByte, model[4]);
    check("R6 data", blk, expBlock(0, 3));

    // R9 stop after the first block byte
    doBlockWrite(7'd3, 8'd4, 1, 8'h5A, acks, mask);
    blockWriteModel(3, 4, 1, 8'h5A);
    check("R9 regs", regsOut, modelFlat());

    // R11 stop right after the command byte
    sendStart();
    writeByte(8'hD6, a);
    writeByte(8'h05, a);
    sendStop();
    check("R11 regs unchanged", regsOut, modelFlat());
    doByteRead(7'd5, d, acks);
    check("R11 next read", d, model[5]);

    // random mix
    for (int it = 0; it < 16; it++) begin
      int op  = $urandom_range(0, 4);
      int idx = $urandom_range(0, 7);
      logic [7:0] v = 8'($urandom);
      case (op)
        0: begin
          doByteWrite(7'(idx), v, acks);
          if (idx < 6) model[idx] = v;
          check("R3 rnd acks", acks, 3'b111);
        end
        1: begin
          doByteRead(7'(idx), d, acks);
          check("R4 rnd data", d, modelRd(idx));
        end
        2: begin
          int cnt = $urandom_range(0, 3);
          int ns  = cnt + $urandom_range(0, 1);
          doBlockWrite(7'(idx), 8'(cnt), ns, v, acks, mask);
          blockWriteModel(idx, cnt, ns, v);
          check("R5 rnd acks", mask, 8'((1 << cnt) - 1));
        end
        3: begin
          int n = $urandom_range(1, 3);
          doBlockRead(7'(idx), n, cntByte, blk, acks);
          check("R6 rnd count", cntByte, model[4]);
          check("R6 rnd data", blk, expBlock(idx, n));
        end
        default: begin
          logic [6:0] ad = 7'($urandom);
          if (ad == 7'h6B) ad = 7'h2C;
          sendStart();
          writeByte({ad, 1'b0}, a);
          sendStop();
          check("R2 rnd nack", a, 1'b0);
        end
      endcase
      check("R3 rnd regs", regsOut, modelFlat());
      check("R8 rnd outEn", outEn, expOe());
    end

    check("R10 drive while clock high", r10Viol, 0);
    done = 1'b1;
    finishRun();
  end

endmodule